// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the frequency a PLL produces from its 16-bit control word and the frequency of its reference clock in Hz. A request is issued with a one-cycle `start_i` pulse while the block is idle. The control word and the reference frequency are captured on that edge. Some time later the block raises `done_o` for one cycle, and the frequency in Hz appears on `freq_o`. That value stays there until the next request completes.

The control word has two mode bits and three divider fields. The power-down mode reports zero. Bypass reports the reference frequency itself. In the normal mode the reference frequency is multiplied by the feedback factor. That product, held in 64 bits, is then divided by the combined input and output divisor. The division is a restoring divider that produces one quotient bit per cycle.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `freq_o` is 0.
- R2: When bit 0 of the control word (power-down) is 1, the result is 0 whatever bit 1 holds. `done_o` rises on the clock edge after the one that accepted the request.
- R3: When bit 0 is 0 and bit 1 (bypass) is 1, the result is the captured reference frequency. `done_o` rises on the clock edge after the one that accepted the request.
- R4: The input divisor is the unsigned field in bits [8:4] plus one, giving 1 to 32.
- R5: The feedback multiplier is twice the unsigned field in bits [15:9] plus one, giving 2 to 256.
- R6: The output divisor is 2 raised to the unsigned field in bits [3:2], giving 1, 2, 4 or 8.
- R7: When bits [1:0] are both 0, the result is the low 32 bits of floor(reference × multiplier / (input divisor × output divisor)). The product and the quotient are computed in 64 bits.
- R8: In the normal mode `done_o` rises no later than 66 cycles after the accepting edge. While the request runs, `busy_o` is 1.
- R9: `done_o` lasts exactly one cycle. `freq_o` changes only in the cycle where `done_o` is 1.
- R10: A `start_i` pulse that arrives while `busy_o` is 1 is ignored. The running request completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when idle |
| ctrl_i | input | 16 | PLL control word |
| parent_hz_i | input | 32 | Reference frequency in Hz |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| freq_o | output | 32 | Computed output frequency in Hz |

## Verification
The bench sweeps every input-divider and output-divider code against feedback codes at both extremes and in the middle. It also varies the reference frequency up to the 32-bit maximum, where the quotient goes past 32 bits and has to be truncated. An off-by-one in any divider encoding shows up as a result that is wrong by a near-integer factor. Reversing the priority of the two mode bits would return the reference frequency where 0 is expected. A second start during a long divide checks that a design which re-latches its inputs, or that takes the bypass short path mid-run, corrupts the pending result or pulses `done_o` early.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int PD_BIT   = 0;
  localparam int BYP_BIT  = 1;
  localparam int ODIV_LSB = 2;
  localparam int ODIV_W   = 2;
  localparam int IDIV_LSB = 4;
  localparam int IDIV_W   = 5;
  localparam int FB_LSB   = 9;
  localparam int FB_W     = 7;
  localparam int CTRL_W   = FB_LSB + FB_W;
  localparam int MULT_W   = FB_W + 2;
  localparam int DVSR_W   = IDIV_W + 1 + (1 << ODIV_W) - 1;

  typedef enum logic [1:0] {MODE_OFF, MODE_BYP, MODE_PLL} pll_mode_e;

  typedef struct packed {
    pll_mode_e           mode;
    logic [MULT_W-1:0]   mult;
    logic [DVSR_W-1:0]   dvsr;
  } pll_cfg_t;
endpackage

// File: rtl/pll_ctrl_decode.sv
module pll_ctrl_decode
  import pll_calc_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output pll_cfg_t          cfg_o
);
  logic [IDIV_W-1:0] idiv_f;
  logic [FB_W-1:0]   fb_f;
  logic [ODIV_W-1:0] odiv_f;
  logic [DVSR_W-1:0] idiv_eff;

  assign idiv_f = ctrl_i[IDIV_LSB +: IDIV_W];
  assign fb_f   = ctrl_i[FB_LSB +: FB_W];
  assign odiv_f = ctrl_i[ODIV_LSB +: ODIV_W];

  assign idiv_eff = DVSR_W'(idiv_f) + DVSR_W'(1);

  always_comb begin
    if (ctrl_i[PD_BIT])       cfg_o.mode = MODE_OFF;
    else if (ctrl_i[BYP_BIT]) cfg_o.mode = MODE_BYP;
    else                      cfg_o.mode = MODE_PLL;
    cfg_o.mult = {(MULT_W-1)'(fb_f) + (MULT_W-1)'(1), 1'b0};
    cfg_o.dvsr = idiv_eff << odiv_f;
  end
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int DW = 64,
  parameter int VW = 9,
  parameter int QW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [QW-1:0] quot_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh_q;
  logic [VW-1:0] rem_q, dvsr_q;
  logic [CW-1:0] cnt_q;
  logic [VW:0]   partial, diff;
  logic          ge;

  assign partial = {rem_q, sh_q[DW-1]};
  assign diff    = partial - {1'b0, dvsr_q};
  assign ge      = partial >= {1'b0, dvsr_q};
  assign quot_o  = sh_q[QW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      dvsr_q <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sh_q   <= dividend_i;
        rem_q  <= '0;
        dvsr_q <= divisor_i;
        cnt_q  <= CW'(DW);
      end else if (cnt_q != '0) begin
        sh_q  <= {sh_q[DW-2:0], ge};
        rem_q <= ge ? diff[VW-1:0] : partial[VW-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int PROD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [FREQ_W-1:0] parent_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [FREQ_W-1:0] freq_o
);
  typedef enum logic {ST_IDLE, ST_DIV} st_e;

  st_e               st_q;
  pll_cfg_t          cfg;
  logic [PROD_W-1:0] product;
  logic              accept, div_start, div_done;
  logic [FREQ_W-1:0] div_quot;

  pll_ctrl_decode u_dec (
    .ctrl_i (ctrl_i),
    .cfg_o  (cfg)
  );

  assign accept    = start_i && (st_q == ST_IDLE);
  assign div_start = accept && (cfg.mode == MODE_PLL);
  assign product   = PROD_W'(parent_hz_i) * PROD_W'(cfg.mult);
  assign busy_o    = (st_q != ST_IDLE);

  pll_restoring_div #(
    .DW (PROD_W),
    .VW (DVSR_W),
    .QW (FREQ_W)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (product),
    .divisor_i  (cfg.dvsr),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      freq_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          unique case (cfg.mode)
            MODE_OFF: begin freq_o <= '0;          done_o <= 1'b1; end
            MODE_BYP: begin freq_o <= parent_hz_i; done_o <= 1'b1; end
            default:  st_q <= ST_DIV;
          endcase
        end
        ST_DIV: if (div_done) begin
          freq_o <= div_quot;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int FREQ_W = 32,
  parameter int CTRL_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [FREQ_W-1:0] parent_hz_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [FREQ_W-1:0] freq_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(freq_o));
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  power_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && ctrl_i[0]) |=> (done_o && freq_o == '0));
  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !ctrl_i[0] && ctrl_i[1])
      |=> (done_o && freq_o == $past(parent_hz_i)));
  // R8
  pll_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && ctrl_i[1:0] == 2'b00) |=> (busy_o && !done_o));
endmodule

bind pll_freq_calc pll_freq_calc_chk #(.FREQ_W(FREQ_W), .CTRL_W(pll_calc_pkg::CTRL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ctrl_i      (ctrl_i),
  .parent_hz_i (parent_hz_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .freq_o      (freq_o)
);

// File: tb/pll_freq_calc_bench.sv
`timescale 1ns/1ps
module pll_freq_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ctrl = '0;
  logic [31:0] parent = '0;
  logic        busy, done;
  logic [31:0] freq;

  int vecs  = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pll_freq_calc u_pll_freq_calc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .ctrl_i      (ctrl),
    .parent_hz_i (parent),
    .busy_o      (busy),
    .done_o      (done),
    .freq_o      (freq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ctrl=%h parent=%0d actual=%0d expected=%0d", req, ctrl, parent, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [15:0] c, input logic [31:0] p);
    longint unsigned m, d, q;
    if (c[0]) return 32'd0;
    if (c[1]) return p;
    m = 64'(2 * (int'(c[15:9]) + 1));
    d = 64'((int'(c[8:4]) + 1) << c[3:2]);
    q = (64'(p) * m) / d;
    return q[31:0];
  endfunction

  // issue one request, wait for done, return latency in cycles
  task automatic run(input logic [15:0] c, input logic [31:0] p, input string req);
    logic [31:0] exp;
    int lat;
    exp = model(c, p);
    @(negedge clk);
    ctrl = c; parent = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 80) begin
      @(negedge clk);
      lat++;
    end
    check(req, freq, exp);
    // R8
    if (!c[0] && !c[1]) check("R8 latency", 32'(lat <= 66), 32'd1);
    else                check({req, " latency"}, 32'(lat), 32'd1);
    @(negedge clk);
    // R9
    check("R9 pulse", {31'd0, done}, 32'd0);
    check("R9 hold", freq, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [31:0] parents [4];
    logic [6:0]  fbs [4];
    int k;
    parents[0] = 32'hFFFF_FFFF; parents[1] = 32'd33_333_333;
    parents[2] = 32'd27_000_000; parents[3] = 32'd1;
    fbs[0] = 7'd0; fbs[1] = 7'd127; fbs[2] = 7'd47; fbs[3] = 7'd21;

    repeat (3) @(negedge clk);
    // R1
    check("R1 freq", freq, 32'd0);
    check("R1 flags", {30'd0, busy, done}, 32'd0);
    rst_n = 1'b1;

    // R2: power-down, with and without bypass
    run(16'h5E3D, 32'd100_000_000, "R2 pd");
    run(16'hFFFF, 32'd123_456_789, "R2 pd over bypass");
    // R3: bypass
    run(16'h5E3E, 32'd100_000_000, "R3 bypass");
    run(16'hFFFE, 32'hFFFF_FFFF, "R3 bypass max");

    // R4 R5 R6 R7: sweep all idiv and odiv codes against feedback extremes
    k = 0;
    for (int id = 0; id < 32; id++)
      for (int od = 0; od < 4; od++)
        for (int f = 0; f < 4; f++) begin
          run({fbs[f], id[4:0], od[1:0], 2'b00}, parents[k % 4], "R4 R5 R6 R7 divide");
          k++;
        end

    // R10: start during busy must be ignored
    @(negedge clk);
    ctrl = {7'd35, 5'd1, 2'd2, 2'b00}; parent = 32'd33_333_333; start = 1'b1;
    @(negedge clk);
    ctrl = 16'h0002; parent = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 no early done", {31'd0, done}, 32'd0);
    begin
      int w = 0;
      while (!done && w < 80) begin @(negedge clk); w++; end
    end
    check("R10 result", freq, model({7'd35, 5'd1, 2'd2, 2'b00}, 32'd33_333_333));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule